// File: doc/BRIEF.md
# Sliced Debug Monitor Multiplexer

This block routes one of several internal observation nodes onto a narrow debug output whose width is fixed at build time. A node wider than the port does not fit in one view. It is therefore split into port-wide slices, and each slice gets its own debug address. The addresses of each node follow one another. Nodes are laid out in index order, so the address map comes straight from the parameter that lists the node widths.

Software writes a debug address over a small configuration port. The written value waits in a pending register. It moves into the active selection only when a frame-start pulse arrives, so one capture never mixes two slices. The output data and its valid strobe are registered. To rebuild a wide node, the host repeats the run once for each slice address.

Top module: `dbg_mon_mux`

## Requirements
- R1: The debug port is `DBG_W` bits wide. Address slice k of a node shows node bits [k*DBG_W +: DBG_W] on `dbg_data_o`.
- R2: Node n takes ceil(width_n / DBG_W) consecutive addresses. These start right after the addresses of nodes 0..n-1. With the default widths (32, 8, 20, 3 for nodes 0..3), addresses 0-3 select node 0, address 4 selects node 1, addresses 5-7 select node 2 and address 8 selects node 3.
- R3: In the topmost partial slice, bits above the node width read as zero. Input bits above a node's declared width never reach the port.
- R4: An address that maps to no node (9 and above with the defaults) drives `dbg_data_o` to zero and holds `dbg_valid_o` low, whatever the node valids are.
- R5: `dbg_valid_o` equals the selected node's valid one clock earlier. `dbg_data_o` is likewise the slice sampled one clock earlier. The valids of other nodes have no effect.
- R6: A configuration write changes only the pending address. The active address changes only on a clock edge where `frame_start_i` is high. If a write and a frame start occur in the same cycle, the written value becomes active.
- R7: `cfg_rdata_o` returns {slice count of the active node, active address}. The address is in the low `ADDR_W` bits. The slice count is 0 for an unmapped address.
- R8: While reset is low, the active and pending addresses are 0, `dbg_data_o` is zero and `dbg_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Write strobe for the pending debug address |
| cfg_wdata_i | input | ADDR_W | Debug address to write |
| cfg_rdata_o | output | SCNT_W+ADDR_W | {slice count, active address} |
| frame_start_i | input | 1 | Frame boundary; copies the pending address into the active address |
| node_data_i | input | NUM_NODES*MAX_NODE_W | Node values; node n sits at [n*MAX_NODE_W +: MAX_NODE_W] |
| node_valid_i | input | NUM_NODES | Per-node valid |
| dbg_data_o | output | DBG_W | Registered selected slice |
| dbg_valid_o | output | 1 | Registered valid of the selected node |

## Verification
A fault in the decoder would show up as the wrong slice, or as a wrong slice count in the readback. Either one is visible one cycle after the active address settles, because the data register is the only stage in the path. A pending/active register that lets a write take effect outside a frame start shows up at once in the readback address, and on the data one cycle later. A wrong padding mask shows up as nonzero upper bits in the top slice of a node whose padding inputs carry junk.

// File: rtl/dbgmux_pkg.sv
package dbgmux_pkg;

  // Number of port-wide slices needed to cover a node of node_w bits.
  function automatic int unsigned slices_for(int unsigned node_w, int unsigned port_w);
    return (node_w + port_w - 1) / port_w;
  endfunction

  // Width of a field that can hold 0..slices_for(node_w, port_w).
  function automatic int unsigned cnt_bits(int unsigned node_w, int unsigned port_w);
    return $clog2(slices_for(node_w, port_w) + 1);
  endfunction

  // Lowest node bit that slice k exposes.
  function automatic int unsigned slice_lsb(int unsigned k, int unsigned port_w);
    return k * port_w;
  endfunction

endpackage

// File: rtl/dbgmux_cfg_reg.sv
module dbgmux_cfg_reg #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              frame_start_i,
  output logic [ADDR_W-1:0] pending_o,
  output logic [ADDR_W-1:0] load_o,
  output logic [ADDR_W-1:0] active_o
);

  logic [ADDR_W-1:0] pending_q;
  logic [ADDR_W-1:0] active_q;

  // Value the active register takes on a frame start; forwards a same-cycle write.
  assign load_o = wr_i ? wdata_i : pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= '0;
      active_q  <= '0;
    end else begin
      if (wr_i) begin
        pending_q <= wdata_i;
      end
      if (frame_start_i) begin
        active_q <= load_o;
      end
    end
  end

  assign pending_o = pending_q;
  assign active_o  = active_q;

endmodule

// File: rtl/dbgmux_addr_decode.sv
module dbgmux_addr_decode
  import dbgmux_pkg::*;
#(
  parameter int unsigned            NUM_NODES   = 4,
  parameter int unsigned            DBG_W       = 8,
  parameter logic [NUM_NODES*8-1:0] NODE_WIDTHS = {8'd3, 8'd20, 8'd8, 8'd32},
  parameter int unsigned            ADDR_W      = 6,
  parameter int unsigned            NODE_IDX_W  = 2,
  parameter int unsigned            SLICE_W     = 2,
  parameter int unsigned            SCNT_W      = 3
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  hit_o,
  output logic [NUM_NODES-1:0]  hit_vec_o,
  output logic [NODE_IDX_W-1:0] node_o,
  output logic [SLICE_W-1:0]    slice_o,
  output logic [SCNT_W-1:0]     cnt_o
);

  // First debug address of node idx: sum of slice counts of lower nodes.
  function automatic int unsigned base_of(int unsigned idx);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < idx; i++) begin
      acc += slices_for(int'(NODE_WIDTHS[i*8 +: 8]), DBG_W);
    end
    return acc;
  endfunction

  logic [ADDR_W:0]    addr_ext;
  logic [SLICE_W-1:0] off_arr [NUM_NODES];
  logic [SCNT_W-1:0]  cnt_arr [NUM_NODES];

  assign addr_ext = {1'b0, addr_i};

  for (genvar n = 0; n < NUM_NODES; n++) begin : g_node
    localparam int unsigned    NW     = int'(NODE_WIDTHS[n*8 +: 8]);
    localparam int unsigned    CNT    = slices_for(NW, DBG_W);
    localparam logic [ADDR_W:0] BASE_A = (ADDR_W+1)'(base_of(n));
    localparam logic [ADDR_W:0] END_A  = (ADDR_W+1)'(base_of(n) + CNT);

    assign hit_vec_o[n] = (addr_ext >= BASE_A) && (addr_ext < END_A);
    assign off_arr[n]   = SLICE_W'(addr_ext - BASE_A);
    assign cnt_arr[n]   = SCNT_W'(CNT);
  end

  always_comb begin
    node_o  = '0;
    slice_o = '0;
    cnt_o   = '0;
    for (int n = 0; n < NUM_NODES; n++) begin
      if (hit_vec_o[n]) begin
        node_o  = NODE_IDX_W'(n);
        slice_o = off_arr[n];
        cnt_o   = cnt_arr[n];
      end
    end
  end

  assign hit_o = |hit_vec_o;

endmodule

// File: rtl/dbgmux_slice_select.sv
module dbgmux_slice_select
  import dbgmux_pkg::*;
#(
  parameter int unsigned            NUM_NODES   = 4,
  parameter int unsigned            DBG_W       = 8,
  parameter int unsigned            MAX_NODE_W  = 32,
  parameter logic [NUM_NODES*8-1:0] NODE_WIDTHS = {8'd3, 8'd20, 8'd8, 8'd32},
  parameter int unsigned            NODE_IDX_W  = 2,
  parameter int unsigned            SLICE_W     = 2
) (
  input  logic [NUM_NODES*MAX_NODE_W-1:0] node_data_i,
  input  logic                            hit_i,
  input  logic [NODE_IDX_W-1:0]           node_i,
  input  logic [SLICE_W-1:0]              slice_i,
  output logic [DBG_W-1:0]                slice_o
);

  localparam int unsigned MAX_SLICES = slices_for(MAX_NODE_W, DBG_W);
  localparam int unsigned PAD_W      = MAX_SLICES * DBG_W;

  logic [PAD_W-1:0] masked [NUM_NODES];
  logic [PAD_W-1:0] sel_word;

  // Clear every bit above each node's declared width, so top slices are zero-padded.
  for (genvar n = 0; n < NUM_NODES; n++) begin : g_mask
    localparam int unsigned          NW   = int'(NODE_WIDTHS[n*8 +: 8]);
    localparam logic [MAX_NODE_W-1:0] MASK = {MAX_NODE_W{1'b1}} >> (MAX_NODE_W - NW);
    assign masked[n] = PAD_W'(node_data_i[n*MAX_NODE_W +: MAX_NODE_W] & MASK);
  end

  always_comb begin
    sel_word = '0;
    for (int n = 0; n < NUM_NODES; n++) begin
      if (hit_i && (node_i == NODE_IDX_W'(n))) begin
        sel_word = masked[n];
      end
    end
  end

  assign slice_o = DBG_W'(sel_word >> slice_lsb(int'(slice_i), DBG_W));

endmodule

// File: rtl/dbg_mon_mux.sv
module dbg_mon_mux
  import dbgmux_pkg::*;
#(
  parameter int unsigned            NUM_NODES   = 4,
  parameter int unsigned            DBG_W       = 8,
  parameter int unsigned            MAX_NODE_W  = 32,
  parameter logic [NUM_NODES*8-1:0] NODE_WIDTHS = {8'd3, 8'd20, 8'd8, 8'd32},
  parameter int unsigned            ADDR_W      = 6
) (
  input  logic                                            clk_i,
  input  logic                                            rst_ni,
  input  logic                                            cfg_wr_i,
  input  logic [ADDR_W-1:0]                               cfg_wdata_i,
  output logic [cnt_bits(MAX_NODE_W, DBG_W)+ADDR_W-1:0]   cfg_rdata_o,
  input  logic                                            frame_start_i,
  input  logic [NUM_NODES*MAX_NODE_W-1:0]                 node_data_i,
  input  logic [NUM_NODES-1:0]                            node_valid_i,
  output logic [DBG_W-1:0]                                dbg_data_o,
  output logic                                            dbg_valid_o
);

  localparam int unsigned MAX_SLICES = slices_for(MAX_NODE_W, DBG_W);
  localparam int unsigned SLICE_W    = (MAX_SLICES > 1) ? $clog2(MAX_SLICES) : 1;
  localparam int unsigned SCNT_W     = cnt_bits(MAX_NODE_W, DBG_W);
  localparam int unsigned NODE_IDX_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1;

  // Named internal events, observed by the bound checker.
  logic [ADDR_W-1:0]     pending_addr;
  logic [ADDR_W-1:0]     load_addr;
  logic [ADDR_W-1:0]     active_addr;
  logic                  dec_hit;
  logic [NUM_NODES-1:0]  dec_hit_vec;
  logic [NODE_IDX_W-1:0] dec_node;
  logic [SLICE_W-1:0]    dec_slice;
  logic [SCNT_W-1:0]     dec_cnt;
  logic                  sel_valid;
  logic [DBG_W-1:0]      sel_slice;

  logic [DBG_W-1:0]      dbg_data_q;
  logic                  dbg_valid_q;

  dbgmux_cfg_reg #(
    .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (cfg_wr_i),
    .wdata_i      (cfg_wdata_i),
    .frame_start_i(frame_start_i),
    .pending_o    (pending_addr),
    .load_o       (load_addr),
    .active_o     (active_addr)
  );

  dbgmux_addr_decode #(
    .NUM_NODES  (NUM_NODES),
    .DBG_W      (DBG_W),
    .NODE_WIDTHS(NODE_WIDTHS),
    .ADDR_W     (ADDR_W),
    .NODE_IDX_W (NODE_IDX_W),
    .SLICE_W    (SLICE_W),
    .SCNT_W     (SCNT_W)
  ) u_decode (
    .addr_i   (active_addr),
    .hit_o    (dec_hit),
    .hit_vec_o(dec_hit_vec),
    .node_o   (dec_node),
    .slice_o  (dec_slice),
    .cnt_o    (dec_cnt)
  );

  dbgmux_slice_select #(
    .NUM_NODES  (NUM_NODES),
    .DBG_W      (DBG_W),
    .MAX_NODE_W (MAX_NODE_W),
    .NODE_WIDTHS(NODE_WIDTHS),
    .NODE_IDX_W (NODE_IDX_W),
    .SLICE_W    (SLICE_W)
  ) u_slice (
    .node_data_i(node_data_i),
    .hit_i      (dec_hit),
    .node_i     (dec_node),
    .slice_i    (dec_slice),
    .slice_o    (sel_slice)
  );

  // The valid of the selected node only; unmapped addresses force it low.
  assign sel_valid = dec_hit & |(node_valid_i & dec_hit_vec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_data_q  <= '0;
      dbg_valid_q <= 1'b0;
    end else begin
      dbg_data_q  <= sel_slice;
      dbg_valid_q <= sel_valid;
    end
  end

  assign dbg_data_o  = dbg_data_q;
  assign dbg_valid_o = dbg_valid_q;
  assign cfg_rdata_o = {dec_cnt, active_addr};

endmodule

// File: rtl/dbg_mon_mux_checker.sv
module dbg_mon_mux_checker #(
  parameter int unsigned NUM_NODES = 4,
  parameter int unsigned DBG_W     = 8,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned SLICE_W   = 2,
  parameter int unsigned SCNT_W    = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     frame_start_i,
  input logic [SCNT_W+ADDR_W-1:0] cfg_rdata_o,
  input logic [DBG_W-1:0]         dbg_data_o,
  input logic                     dbg_valid_o,
  input logic [ADDR_W-1:0]        load_addr,
  input logic                     dec_hit,
  input logic [NUM_NODES-1:0]     dec_hit_vec,
  input logic [SLICE_W-1:0]       dec_slice,
  input logic [SCNT_W-1:0]        dec_cnt,
  input logic                     sel_valid
);

  assert_unmapped_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_hit |=> (!dbg_valid_o && (dbg_data_o == '0)));

  assert_valid_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_hit |=> (dbg_valid_o == $past(sel_valid)));

  assert_active_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(cfg_rdata_o[ADDR_W-1:0]));

  assert_frame_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (cfg_rdata_o[ADDR_W-1:0] == $past(load_addr)));

  assert_single_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dec_hit_vec));

  assert_slice_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_hit |-> (SCNT_W'(dec_slice) < dec_cnt));

  assert_unmapped_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_hit |-> (cfg_rdata_o[SCNT_W+ADDR_W-1:ADDR_W] == '0));

endmodule

bind dbg_mon_mux dbg_mon_mux_checker #(
  .NUM_NODES(NUM_NODES),
  .DBG_W    (DBG_W),
  .ADDR_W   (ADDR_W),
  .SLICE_W  (SLICE_W),
  .SCNT_W   (SCNT_W)
) u_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .dbg_data_o   (dbg_data_o),
  .dbg_valid_o  (dbg_valid_o),
  .load_addr    (load_addr),
  .dec_hit      (dec_hit),
  .dec_hit_vec  (dec_hit_vec),
  .dec_slice    (dec_slice),
  .dec_cnt      (dec_cnt),
  .sel_valid    (sel_valid)
);

// File: tb/dbg_mon_mux_bench.sv
`timescale 1ns/1ps
module dbg_mon_mux_bench;

  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DBG_W  = 8;
  localparam int unsigned NVEC   = 13;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DBG_W-1:0]  data;
    logic              vld;
    logic [2:0]        cnt;
  } vec_t;

  // Address map per R2, slices per R1, padding per R3, unmapped per R4, count per R7.
  localparam vec_t VECS [NVEC] = '{
    '{6'd0,  8'hD4, 1'b1, 3'd4},
    '{6'd1,  8'hC3, 1'b1, 3'd4},
    '{6'd2,  8'hB2, 1'b1, 3'd4},
    '{6'd3,  8'hA1, 1'b1, 3'd4},
    '{6'd4,  8'h5E, 1'b1, 3'd1},
    '{6'd5,  8'h34, 1'b1, 3'd3},
    '{6'd6,  8'h12, 1'b1, 3'd3},
    '{6'd7,  8'h0F, 1'b1, 3'd3},
    '{6'd8,  8'h05, 1'b1, 3'd1},
    '{6'd9,  8'h00, 1'b0, 3'd0},
    '{6'd63, 8'h00, 1'b0, 3'd0},
    '{6'd33, 8'h00, 1'b0, 3'd0},
    '{6'd2,  8'hB2, 1'b1, 3'd4}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr = 1'b0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic [8:0]        cfg_rdata;
  logic              frame_start = 1'b0;
  logic [127:0]      node_data;
  logic [3:0]        node_valid = 4'b0000;
  logic [DBG_W-1:0]  dbg_data;
  logic              dbg_valid;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  bit          done     = 1'b0;

  always #2 clk = ~clk;

  dbg_mon_mux u_dbg_mon_mux (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_wr_i     (cfg_wr),
    .cfg_wdata_i  (cfg_wdata),
    .cfg_rdata_o  (cfg_rdata),
    .frame_start_i(frame_start),
    .node_data_i  (node_data),
    .node_valid_i (node_valid),
    .dbg_data_o   (dbg_data),
    .dbg_valid_o  (dbg_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // Junk above each node's declared width exercises R3 masking.
    node_data = {32'hFFFF_FFFD, 32'hABCF_1234, 32'h1234_565E, 32'hA1B2_C3D4};
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 data", 32'(dbg_data), 32'h0);
    check("R8 valid", 32'(dbg_valid), 32'h0);
    check("R8 readback", 32'(cfg_rdata), {23'd0, 3'd4, 6'd0});
    rst_n = 1'b1;
    node_valid = 4'b1111;

    // Table walk: same-cycle write and frame start (R6 forwarding).
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = VECS[i].addr; frame_start = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; frame_start = 1'b0;
      @(negedge clk);
      check("R1/R2/R3/R4 data", 32'(dbg_data), 32'(VECS[i].data));
      check("R4/R5 valid", 32'(dbg_valid), 32'(VECS[i].vld));
      check("R7 readback", 32'(cfg_rdata), {23'd0, VECS[i].cnt, VECS[i].addr});
    end

    // R6: write without frame start has no visible effect.
    cfg_wr = 1'b1; cfg_wdata = 6'd4;
    @(negedge clk);
    cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 hold readback", 32'(cfg_rdata), {23'd0, 3'd4, 6'd2});
    check("R6 hold data", 32'(dbg_data), 32'h0000_00B2);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check("R6 load readback", 32'(cfg_rdata), {23'd0, 3'd1, 6'd4});
    @(negedge clk);
    check("R6 load data", 32'(dbg_data), 32'h0000_005E);

    // R5: selected valid drops, others stay high; one-cycle latency.
    node_valid = 4'b1101;
    check("R5 valid before edge", 32'(dbg_valid), 32'h1);
    @(negedge clk);
    check("R5 valid follows selected", 32'(dbg_valid), 32'h0);
    node_data[63:32] = 32'h0000_0077;
    node_valid = 4'b0010;
    check("R5 data before edge", 32'(dbg_data), 32'h0000_005E);
    @(negedge clk);
    check("R5 data after edge", 32'(dbg_data), 32'h0000_0077);
    check("R5 valid after edge", 32'(dbg_valid), 32'h1);

    // R4: unmapped address with all valids high stays quiet.
    node_valid = 4'b1111;
    cfg_wr = 1'b1; cfg_wdata = 6'd12; frame_start = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; frame_start = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 unmapped data", 32'(dbg_data), 32'h0);
    check("R4 unmapped valid", 32'(dbg_valid), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule